// File: doc/BRIEF.md
# Membership Breakpoint Tuning Unit

This unit reshapes the breakpoints of a five-set fuzzy partition with one tuning code, so a fuzzifier can be retuned by changing a single number. Each input universe is described by a fixed vector of nominal breakpoints, sorted from the most negative to the most positive. The unit scales each breakpoint into a signed fixed-point range of -1 to +1 and bends its magnitude with a power curve picked by the code. It then scales the result back into the original universe and holds the tuned vector on its outputs for the fuzzifier.

Two breakpoint vectors are kept, one for the error input and one for the change-of-error input, and the same code drives both. Exponents below one push the inner breakpoints outward, which widens the centre sets. Exponents above one pull them toward zero, which narrows the centre sets. When the code changes, the unit rebuilds the vectors one breakpoint index per clock and lowers its valid flag until the rebuild is complete.

Top module: `bp_tuner`

## Requirements
- R1: After reset, both outputs hold their nominal vectors. With the defaults, the error vector is -80,-60,-40,-20,0,20,40,60,80 and the change-of-error vector is -80,-50,-30,-10,0,10,30,50,80, at indices 0 to 8. Each point is 8-bit two's complement. bp_valid_o is 1.
- R2: A nominal point p is normalised to the Q1.7 magnitude q = floor(|p|*128/80 + 0.5), where 128 means 1.0. Its sign is kept aside.
- R3: The tuned magnitude is t = floor(128*(q/128)^e + 0.5), with e = 2^((code-8)/4) for the 4-bit code 0..15. For example, code 4 maps point 20 to 40 and code 12 maps point 60 to 45.
- R4: Code 8 gives e = 1 and leaves every default breakpoint unchanged.
- R5: A code below 8 moves every inner point farther from zero (expansion). A code above 8 moves every inner point closer to zero (compression).
- R6: Tuning is odd-symmetric. A point and its mirror stay negatives of each other, and the points -80, 0 and +80 never move.
- R7: Renormalisation gives floor(t*80/128 + 0.5) with the saved sign applied. For example, code 4 maps point 60 to 69.
- R8: The change-of-error vector is tuned with the same code as the error vector.
- R9: A code that differs from the one in use and is present at a rising edge clears bp_valid_o after that edge. Call that edge the first edge. Index k of both vectors takes its new value after edge k+2, and bp_valid_o returns to 1 after edge 10.
- R10: A code equal to the one in use starts nothing: bp_valid_o stays 1 and the outputs stay unchanged.
- R11: A code change during a rebuild restarts the rebuild from index 0 with the newest code. The finished vectors then reflect only that code.
- R12: Whenever bp_valid_o is 1, each vector is non-decreasing from index 0 to index 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_code | input | 4 | Tuning code; 8 is neutral |
| bp_err_o | output | 9x8 | Tuned error breakpoints, index 0 lowest |
| bp_derr_o | output | 9x8 | Tuned change-of-error breakpoints |
| bp_valid_o | output | 1 | Both vectors fully rebuilt for the current code |

## Verification
A code change is seen at the first rising edge after it is driven. bp_valid_o falls after that edge, index k settles after edge k+2, and bp_valid_o rises after edge 10. The bench's reference model follows the same edge count for each index. The bench compares every output on the falling edge of every cycle, so it samples between updates and never at the edge where an output changes. Targeted checks wait for valid and count the edges it takes, which must be ten. Only after that do they test values, symmetry, ordering and the expansion or compression direction.

// File: rtl/bptune_pkg.sv
package bptune_pkg;
    localparam int CODE_W     = 4;
    localparam int NCODES     = 1 << CODE_W;
    localparam int IDENT_CODE = NCODES / 2;
    localparam int CODES_PER_OCTAVE = 4;
    localparam int FRAC       = 7;
    localparam int MAG_MAX    = 1 << FRAC;
    localparam int Q_W        = FRAC + 1;
    localparam int BP_W       = 8;
    localparam int UNIVERSE   = 80;
    localparam int PTS        = 9;
    localparam int IDX_W      = $clog2(PTS);
    localparam int NCH        = 2;

    typedef logic [CODE_W-1:0]      code_t;
    typedef logic [Q_W-1:0]         qmag_t;
    typedef logic signed [BP_W-1:0] bp_t;
    typedef logic [IDX_W-1:0]       idx_t;

    typedef struct packed {
        code_t code;
        idx_t  idx;
        logic  busy;
        logic  valid;
    } seq_st_t;

    // Table entry: rounded Q1.7 magnitude of (mag/1.0)^e, e = 2^((code-ident)/steps)
    function automatic int tune_entry(int code, int mag);
        real e;
        real x;
        e = 2.0 ** ((real'(code) - real'(IDENT_CODE)) / real'(CODES_PER_OCTAVE));
        x = (real'(mag) / real'(MAG_MAX)) ** e;
        return int'($floor(x * real'(MAG_MAX) + 0.5));
    endfunction
endpackage

// File: rtl/tune_lut.sv
module tune_lut
    import bptune_pkg::*;
(
    input  code_t code_i,
    input  qmag_t mag_i,
    output qmag_t mag_o
);
    logic [Q_W-1:0] rom [NCODES][MAG_MAX+1];

    for (genvar c = 0; c < NCODES; c++) begin : g_code
        for (genvar m = 0; m <= MAG_MAX; m++) begin : g_mag
            localparam int ENTRY = tune_entry(c, m);
            assign rom[c][m] = Q_W'(ENTRY);
        end
    end

    always_comb begin
        if (mag_i > qmag_t'(MAG_MAX)) begin
            mag_o = rom[code_i][MAG_MAX];
        end else begin
            mag_o = rom[code_i][mag_i];
        end
    end
endmodule

// File: rtl/bp_lane.sv
module bp_lane
    import bptune_pkg::*;
#(
    parameter int UNIV = UNIVERSE
) (
    input  code_t code_i,
    input  bp_t   nom_i,
    output bp_t   tuned_o
);
    logic            neg;
    logic [BP_W-1:0] mag;
    qmag_t           norm_q;
    qmag_t           bent_q;
    logic [BP_W-1:0] out_mag;
    int              scaled;
    int              back;

    // Normalise: magnitude into Q1.7, nearest, sign held aside
    always_comb begin
        neg    = nom_i[BP_W-1];
        mag    = neg ? BP_W'(-nom_i) : BP_W'(nom_i);
        scaled = (int'(mag) * MAG_MAX + UNIV / 2) / UNIV;
        norm_q = (scaled > MAG_MAX) ? Q_W'(MAG_MAX) : Q_W'(scaled);
    end

    tune_lut u_lut (
        .code_i (code_i),
        .mag_i  (norm_q),
        .mag_o  (bent_q)
    );

    // Renormalise to the universe, nearest, sign restored
    always_comb begin
        back    = (int'(bent_q) * UNIV + MAG_MAX / 2) / MAG_MAX;
        out_mag = BP_W'(back);
        tuned_o = neg ? bp_t'(-out_mag) : bp_t'(out_mag);
    end
endmodule

// File: rtl/bp_seq.sv
module bp_seq
    import bptune_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  code_t code_i,
    output code_t code_o,
    output idx_t  idx_o,
    output logic  wr_o,
    output logic  busy_o,
    output logic  valid_o
);
    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wr_o = 1'b0;
        if (code_i != st_q.code) begin
            st_d.code  = code_i;
            st_d.idx   = '0;
            st_d.busy  = 1'b1;
            st_d.valid = 1'b0;
        end else if (st_q.busy) begin
            wr_o = 1'b1;
            if (st_q.idx == idx_t'(PTS - 1)) begin
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
            end else begin
                st_d.idx = st_q.idx + idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{code: code_t'(IDENT_CODE), idx: '0, busy: 1'b0, valid: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign idx_o   = st_q.idx;
    assign busy_o  = st_q.busy;
    assign valid_o = st_q.valid;

    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i != st_q.code) |=> !valid_o);
    p_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(busy_o));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && code_i == st_q.code) |=> (valid_o && $stable(code_o)));
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && code_i != st_q.code) |=> (busy_o && idx_o == '0));
endmodule

// File: rtl/bp_tuner.sv
module bp_tuner
    import bptune_pkg::*;
#(
    parameter int UNIV = UNIVERSE,
    parameter logic [PTS-1:0][BP_W-1:0] NOM_ERR =
        {8'sd80, 8'sd60, 8'sd40, 8'sd20, 8'sd0, -8'sd20, -8'sd40, -8'sd60, -8'sd80},
    parameter logic [PTS-1:0][BP_W-1:0] NOM_DERR =
        {8'sd80, 8'sd50, 8'sd30, 8'sd10, 8'sd0, -8'sd10, -8'sd30, -8'sd50, -8'sd80}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CODE_W-1:0]          tune_code,
    output logic [PTS-1:0][BP_W-1:0]   bp_err_o,
    output logic [PTS-1:0][BP_W-1:0]   bp_derr_o,
    output logic                       bp_valid_o
);
    localparam logic [NCH-1:0][PTS-1:0][BP_W-1:0] NOM_ALL = {NOM_DERR, NOM_ERR};

    typedef struct packed {
        logic [NCH-1:0][PTS-1:0][BP_W-1:0] bp;
    } store_t;

    store_t store_d, store_q;
    code_t  code_q;
    idx_t   wr_idx;
    logic   wr;
    logic   busy;
    logic   valid;
    bp_t    nom_sel  [NCH];
    bp_t    lane_out [NCH];

    bp_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (tune_code),
        .code_o  (code_q),
        .idx_o   (wr_idx),
        .wr_o    (wr),
        .busy_o  (busy),
        .valid_o (valid)
    );

    function automatic logic is_ordered(logic [PTS-1:0][BP_W-1:0] v);
        for (int k = 0; k < PTS - 1; k++) begin
            if ($signed(v[k]) > $signed(v[k+1])) return 1'b0;
        end
        return 1'b1;
    endfunction

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        assign nom_sel[ch] = bp_t'(NOM_ALL[ch][wr_idx]);

        bp_lane #(.UNIV(UNIV)) u_lane (
            .code_i  (code_q),
            .nom_i   (nom_sel[ch]),
            .tuned_o (lane_out[ch])
        );

        p_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && code_q == code_t'(IDENT_CODE)) |-> (lane_out[ch] == nom_sel[ch]));
        p_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && (int'(nom_sel[ch]) == 0 || int'(nom_sel[ch]) == UNIV ||
                    int'(nom_sel[ch]) == -UNIV)) |-> (lane_out[ch] == nom_sel[ch]));
        p_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            wr |-> (int'(lane_out[ch]) <= UNIV && int'(lane_out[ch]) >= -UNIV));
        p_order_r12: assert property (@(posedge clk) disable iff (!rst_n)
            valid |-> is_ordered(store_q.bp[ch]));
    end

    always_comb begin
        store_d = store_q;
        if (wr) begin
            for (int ch = 0; ch < NCH; ch++) begin
                store_d.bp[ch][wr_idx] = lane_out[ch];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q.bp <= NOM_ALL;
        end else begin
            store_q <= store_d;
        end
    end

    assign bp_err_o   = store_q.bp[0];
    assign bp_derr_o  = store_q.bp[1];
    assign bp_valid_o = valid;
endmodule

// File: tb/bp_tuner_tb.sv
module bp_tuner_tb;
    import bptune_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CODE_W-1:0] tune_code = 4'd8;
    logic [PTS-1:0][BP_W-1:0] bp_err_o, bp_derr_o;
    logic bp_valid_o;

    always #10 clk = ~clk;

    bp_tuner u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_code  (tune_code),
        .bp_err_o   (bp_err_o),
        .bp_derr_o  (bp_derr_o),
        .bp_valid_o (bp_valid_o)
    );

    int nom_a [PTS] = '{-80, -60, -40, -20, 0, 20, 40, 60, 80};
    int nom_b [PTS] = '{-80, -50, -30, -10, 0, 10, 30, 50, 80};
    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit reported = 0;

    // Reference: the three arithmetic steps of R2, R3 and R7 in real arithmetic
    function automatic int ref_bp(int nom, int code);
        int  mag, q, t, o;
        real e;
        mag = (nom < 0) ? -nom : nom;
        q = int'($floor(real'(mag) * 128.0 / 80.0 + 0.5));
        e = 2.0 ** ((real'(code) - 8.0) / 4.0);
        t = int'($floor(128.0 * ((real'(q) / 128.0) ** e) + 0.5));
        o = int'($floor(real'(t) * 80.0 / 128.0 + 0.5));
        return (nom < 0) ? -o : o;
    endfunction

    function automatic int pa(int k);
        return int'($signed(bp_err_o[k]));
    endfunction
    function automatic int pb(int k);
        return int'($signed(bp_derr_o[k]));
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    // Cycle model: code held, points rebuilt one index per edge
    int m_code, m_idx;
    bit m_busy, m_valid;
    int m_a [PTS];
    int m_b [PTS];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 8; m_idx = 0; m_busy = 0; m_valid = 1;
            for (int k = 0; k < PTS; k++) begin
                m_a[k] = nom_a[k];
                m_b[k] = nom_b[k];
            end
        end else if (int'(tune_code) != m_code) begin
            m_code = int'(tune_code); m_idx = 0; m_busy = 1; m_valid = 0;
        end else if (m_busy) begin
            m_a[m_idx] = ref_bp(nom_a[m_idx], m_code);
            m_b[m_idx] = ref_bp(nom_b[m_idx], m_code);
            if (m_idx == PTS - 1) begin
                m_busy = 0; m_valid = 1;
            end else begin
                m_idx++;
            end
        end
    end

    // R9: every cycle, all outputs against the model
    always @(negedge clk) begin
        if (rst_n && started) begin
            int bad;
            bad = -1;
            for (int k = 0; k < PTS; k++) begin
                if (bad < 0 && (pa(k) != m_a[k] || pb(k) != m_b[k])) bad = k;
            end
            checks++;
            if (bad >= 0) begin
                errors++;
                $display("FAIL R9 cycle index %0d: actual=%0d/%0d expected=%0d/%0d",
                         bad, pa(bad), pb(bad), m_a[bad], m_b[bad]);
            end else if (bp_valid_o !== m_valid) begin
                errors++;
                $display("FAIL R9 cycle valid: actual=%0d expected=%0d", bp_valid_o, m_valid);
            end
        end
    end

    task automatic wait_valid(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bp_valid_o && n < 40);
    endtask

    task automatic check_vectors(string tag, int code);
        for (int k = 0; k < PTS; k++) begin
            chk({tag, " err"}, pa(k), ref_bp(nom_a[k], code));
            chk({tag, " derr"}, pb(k), ref_bp(nom_b[k], code));
        end
    endtask

    task automatic check_shape(int code);
        for (int k = 0; k < PTS; k++) begin
            chk("R6 mirror", pa(k), -pa(PTS - 1 - k));
            if (k < PTS - 1) chk("R12 order", int'(pa(k) <= pa(k + 1) && pb(k) <= pb(k + 1)), 1);
        end
        chk("R6 zero fixed", pa(4), 0);
        chk("R6 low end fixed", pa(0), -80);
        chk("R6 high end fixed", pb(8), 80);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        @(negedge clk);
        chk("R1 valid after reset", int'(bp_valid_o), 1);
        for (int k = 0; k < PTS; k++) begin
            chk("R1 nominal err", pa(k), nom_a[k]);
            chk("R1 nominal derr", pb(k), nom_b[k]);
        end

        // R10: the code in use again starts nothing
        repeat (5) begin
            @(negedge clk);
            chk("R10 valid held", int'(bp_valid_o), 1);
        end

        // R5 expansion, R9 timing
        tune_code = 4'd0;
        @(negedge clk);
        chk("R9 valid drops", int'(bp_valid_o), 0);
        wait_valid(n);
        chk("R9 edges to valid", n + 1, PTS + 1);
        check_vectors("R3 code0", 0);
        check_vectors("R8 code0", 0);
        for (int k = 1; k < PTS - 1; k++) begin
            if (k != 4) chk("R5 expansion", int'((pa(k) < 0 ? -pa(k) : pa(k)) > (nom_a[k] < 0 ? -nom_a[k] : nom_a[k])), 1);
        end
        check_shape(0);

        // R5 compression
        tune_code = 4'd15;
        wait_valid(n);
        chk("R9 edges to valid", n, PTS + 1);
        check_vectors("R3 code15", 15);
        for (int k = 1; k < PTS - 1; k++) begin
            if (k != 4) chk("R5 compression", int'((pa(k) < 0 ? -pa(k) : pa(k)) < (nom_a[k] < 0 ? -nom_a[k] : nom_a[k])), 1);
        end
        check_shape(15);

        // R2, R3, R7 hand-computed values
        tune_code = 4'd4;
        wait_valid(n);
        chk("R3 code4 point 20", pa(5), 40);
        chk("R7 code4 point 60", pa(7), 69);
        chk("R2 code4 point -40", pa(2), -57);
        tune_code = 4'd12;
        wait_valid(n);
        chk("R3 code12 point 60", pa(7), 45);
        chk("R7 code12 point 20", pa(5), 5);
        chk("R2 code12 point 40", pa(6), 20);

        // R4 identity restored
        tune_code = 4'd8;
        wait_valid(n);
        for (int k = 0; k < PTS; k++) begin
            chk("R4 identity err", pa(k), nom_a[k]);
            chk("R4 identity derr", pb(k), nom_b[k]);
        end

        // R11 restart mid-rebuild
        tune_code = 4'd4;
        repeat (3) @(negedge clk);
        tune_code = 4'd12;
        wait_valid(n);
        chk("R11 edges after restart", n, PTS + 1);
        check_vectors("R11 final code12", 12);

        // R3 and R8 sweep of all codes
        for (int c = 0; c < NCODES; c++) begin
            tune_code = CODE_W'(c);
            wait_valid(n);
            check_vectors("R3 sweep", c);
        end

        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end
endmodule